// File: doc/BRIEF.md
# Interrupt Interface Enable Register

This block is a 32-bit hypervisor-level control register. It chooses whether the CPU interface of the interrupt controller is reached through system registers or through its memory-mapped window. It also holds two bits that stop interrupt bypass, and one bit that lets the lower privilege level reach its own enable register. It has a write port (data bus plus byte strobes) and a combinational read port. Configuration straps describe the platform: bypass support, system-register-only operation, whether the top privilege level exists, and the security-disable flag. The two bypass bits can mirror a register at the higher privilege level, and the block can forward writes to that register.

Besides the readback value, the block drives decoded control outputs for the rest of the interface: the effective enable, a trap request for lower-level accesses, the two bypass-disable controls, an "interface registers undefined" signal, and a sticky flag that records a write clearing the system-register enable.

Top module: `intc_sysif_enable`

## Requirements
- R1: Read data bits 31..4 are always 0, and writes to those bits have no visible effect.
- R2: Bit 3 is the lower-level enable. A write with `wr_en`=1 and `wr_strb[0]`=1 stores `wr_data[3]`. `trap_lower` is 1 exactly when the effective enable is 0.
- R3: While the readback of bit 0 (system-register enable) is 0, `eff_enable` is 1 and `trap_lower` is 0. Read bit 3 still returns the stored value.
- R4: Bit 2 disables IRQ bypass and bit 1 disables FIQ bypass, with 1 meaning disabled. `irq_bypass_off` and `fiq_bypass_off` follow the read bits. With bypass supported and no top level, the bits are stored locally from `wr_data[2:1]`.
- R5: With `cfg_top_present`=1 and `cfg_sec_disable`=0, bits 2 and 1 read `up_dib` and `up_dfb`. Writes neither change them nor raise `up_wr_en`.
- R6: With `cfg_top_present`=1 and `cfg_sec_disable`=1, bits 2 and 1 read `up_dib` and `up_dfb`. During a write, `up_wr_en`=1 and `up_wr_dib`/`up_wr_dfb` carry `wr_data[2]`/`wr_data[1]` in that same cycle.
- R7: With `cfg_no_bypass`=1, bits 2 and 1 read as 1, writes are ignored and `up_wr_en` stays 0. This takes precedence over R5 and R6.
- R8: With `cfg_sysreg_only`=1, bit 0 reads as 1 and ignores writes. If `cfg_lock_enable`=1 as well, bit 3 also reads as 1 and ignores writes.
- R9: `sysreg_undef` is 1 exactly when the readback of bit 0 is 0.
- R10: A write that takes bit 0 from a readback of 1 to 0 sets `sre_clear_err`. The write still takes effect. The flag stays set until reset.
- R11: A synchronous reset clears the stored bits 3..0 and the error flag. Strapped fields read 1. A write with `wr_strb[0]`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_strb | input | 4 | Byte strobes; byte 0 holds all fields |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Readback value |
| cfg_no_bypass | input | 1 | Platform lacks interrupt bypass |
| cfg_sysreg_only | input | 1 | Only the system-register path exists |
| cfg_lock_enable | input | 1 | With system-register-only, also pin enable to 1 |
| cfg_top_present | input | 1 | Higher privilege level exists |
| cfg_sec_disable | input | 1 | Security-disable flag |
| up_dib | input | 1 | Higher-level IRQ bypass-disable value |
| up_dfb | input | 1 | Higher-level FIQ bypass-disable value |
| up_wr_en | output | 1 | Write forwarded to higher-level register |
| up_wr_dib | output | 1 | Forwarded IRQ bypass-disable data |
| up_wr_dfb | output | 1 | Forwarded FIQ bypass-disable data |
| eff_enable | output | 1 | Effective lower-level enable |
| trap_lower | output | 1 | Trap request for lower-level accesses |
| irq_bypass_off | output | 1 | IRQ bypass disabled |
| fiq_bypass_off | output | 1 | FIQ bypass disabled |
| sysreg_undef | output | 1 | Interface system registers undefined |
| sre_clear_err | output | 1 | Sticky: system-register enable was cleared |

## Verification
The assertions assume the configuration straps are static between resets. The read-only mirror checks also assume `up_dib`/`up_dfb` are stable across a write. The bench respects both. It changes straps only while `rst` is high and reapplies reset for each of the 32 strap combinations. It changes the higher-level values only in cycles without a write. Within each configuration it sweeps every value of the field nibble against every higher-level pair, with varying junk in the reserved bits. It also issues a write with strobe 0 off.

// File: rtl/intc_sysif_pkg.sv
package intc_sysif_pkg;
    localparam int REG_W   = 32;
    localparam int STRB_W  = REG_W / 8;
    localparam int FIELD_W = 4;

    // Bit order matches register positions 3..0
    typedef struct packed {
        logic en;
        logic dib;
        logic dfb;
        logic sre;
    } fields_t;

    typedef struct packed {
        logic no_bypass;
        logic sysreg_only;
        logic lock_enable;
        logic top_present;
        logic sec_disable;
    } straps_t;

    function automatic logic write_fires(logic en, logic [STRB_W-1:0] strb);
        return en & strb[0];
    endfunction

    function automatic logic bypass_local(straps_t s);
        return !s.no_bypass && !s.top_present;
    endfunction

    function automatic logic enable_locked(straps_t s);
        return s.sysreg_only && s.lock_enable;
    endfunction
endpackage

// File: rtl/intc_sysif_store.sv
module intc_sysif_store
    import intc_sysif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  straps_t straps,
    input  logic    wr_fire,
    input  fields_t wr_f,
    input  logic    cur_sre,
    output fields_t q,
    output logic    err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            err <= 1'b0;
        end else if (wr_fire) begin
            if (!straps.sysreg_only) begin
                q.sre <= wr_f.sre;
                if (cur_sre && !wr_f.sre) err <= 1'b1;
            end
            if (!enable_locked(straps)) q.en <= wr_f.en;
            if (bypass_local(straps)) begin
                q.dib <= wr_f.dib;
                q.dfb <= wr_f.dfb;
            end
        end
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    p_mirror_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !bypass_local(straps)) |=> $stable({q.dib, q.dfb}));
endmodule

// File: rtl/intc_sysif_view.sv
module intc_sysif_view
    import intc_sysif_pkg::*;
(
    input  straps_t straps,
    input  fields_t q,
    input  logic    up_dib,
    input  logic    up_dfb,
    input  logic    wr_fire,
    input  fields_t wr_f,
    output fields_t rd,
    output logic    eff_en,
    output logic    fwd_en,
    output logic    fwd_dib,
    output logic    fwd_dfb
);
    always_comb begin
        rd.sre = straps.sysreg_only ? 1'b1 : q.sre;
        rd.en  = enable_locked(straps) ? 1'b1 : q.en;
        if (straps.no_bypass) begin
            rd.dib = 1'b1;
            rd.dfb = 1'b1;
        end else if (straps.top_present) begin
            rd.dib = up_dib;
            rd.dfb = up_dfb;
        end else begin
            rd.dib = q.dib;
            rd.dfb = q.dfb;
        end
        eff_en  = rd.en | ~rd.sre;
        fwd_en  = wr_fire && straps.top_present && straps.sec_disable
                  && !straps.no_bypass;
        fwd_dib = wr_f.dib;
        fwd_dfb = wr_f.dfb;
    end
endmodule

// File: rtl/intc_sysif_enable.sv
module intc_sysif_enable
    import intc_sysif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cfg_no_bypass,
    input  logic              cfg_sysreg_only,
    input  logic              cfg_lock_enable,
    input  logic              cfg_top_present,
    input  logic              cfg_sec_disable,
    input  logic              up_dib,
    input  logic              up_dfb,
    output logic              up_wr_en,
    output logic              up_wr_dib,
    output logic              up_wr_dfb,
    output logic              eff_enable,
    output logic              trap_lower,
    output logic              irq_bypass_off,
    output logic              fiq_bypass_off,
    output logic              sysreg_undef,
    output logic              sre_clear_err
);
    straps_t straps;
    fields_t wr_f, q, rd;
    logic    wr_fire;
    logic    unused_hi;

    assign straps    = '{no_bypass: cfg_no_bypass, sysreg_only: cfg_sysreg_only,
                         lock_enable: cfg_lock_enable, top_present: cfg_top_present,
                         sec_disable: cfg_sec_disable};
    assign wr_f      = fields_t'(wr_data[FIELD_W-1:0]);
    assign wr_fire   = write_fires(wr_en, wr_strb);
    assign unused_hi = ^{wr_data[REG_W-1:FIELD_W], wr_strb[STRB_W-1:1]};

    intc_sysif_store u_store (
        .clk(clk), .rst(rst), .straps(straps), .wr_fire(wr_fire),
        .wr_f(wr_f), .cur_sre(rd.sre), .q(q), .err(sre_clear_err)
    );

    intc_sysif_view u_view (
        .straps(straps), .q(q), .up_dib(up_dib), .up_dfb(up_dfb),
        .wr_fire(wr_fire), .wr_f(wr_f), .rd(rd), .eff_en(eff_enable),
        .fwd_en(up_wr_en), .fwd_dib(up_wr_dib), .fwd_dfb(up_wr_dfb)
    );

    assign rd_data        = {{(REG_W-FIELD_W){1'b0}}, rd};
    assign trap_lower     = ~eff_enable;
    assign irq_bypass_off = rd.dib;
    assign fiq_bypass_off = rd.dfb;
    assign sysreg_undef   = ~rd.sre;

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:FIELD_W] == '0);
    p_no_trap_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_data[0] |-> (eff_enable && !trap_lower));
    p_nobyp_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_no_bypass |-> (rd_data[2:1] == 2'b11 && !up_wr_en));
    p_ro_alias_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_top_present && !cfg_sec_disable) |-> !up_wr_en);
    p_sre_pinned_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_sysreg_only |-> (rd_data[0] && !sysreg_undef));
    p_undef_r9: assert property (@(posedge clk) disable iff (rst)
        sysreg_undef != rd_data[0]);
endmodule

// File: tb/test_intc_sysif_enable.sv
module test_intc_sysif_enable;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = 4'h0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        nb = 0, so = 0, lk = 0, tp = 0, sd = 0;
    logic        up_dib = 0, up_dfb = 0;
    logic        up_wr_en, up_wr_dib, up_wr_dfb;
    logic        eff_enable, trap_lower, irq_bypass_off, fiq_bypass_off;
    logic        sysreg_undef, sre_clear_err;

    int checks = 0;
    int failures = 0;
    logic m_en, m_dib, m_dfb, m_sre, m_err;

    always #10 clk = ~clk;

    intc_sysif_enable i_intc_sysif_enable (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_no_bypass(nb), .cfg_sysreg_only(so),
        .cfg_lock_enable(lk), .cfg_top_present(tp), .cfg_sec_disable(sd),
        .up_dib(up_dib), .up_dfb(up_dfb), .up_wr_en(up_wr_en),
        .up_wr_dib(up_wr_dib), .up_wr_dfb(up_wr_dfb), .eff_enable(eff_enable),
        .trap_lower(trap_lower), .irq_bypass_off(irq_bypass_off),
        .fiq_bypass_off(fiq_bypass_off), .sysreg_undef(sysreg_undef),
        .sre_clear_err(sre_clear_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (cfg nb=%0b so=%0b lk=%0b tp=%0b sd=%0b)",
                     tag, act, exp, nb, so, lk, tp, sd);
        end
    endtask

    function automatic logic e_sre(); return so ? 1'b1 : m_sre; endfunction
    function automatic logic e_en();  return (so && lk) ? 1'b1 : m_en; endfunction
    function automatic logic e_dib(); return nb ? 1'b1 : (tp ? up_dib : m_dib); endfunction
    function automatic logic e_dfb(); return nb ? 1'b1 : (tp ? up_dfb : m_dfb); endfunction

    function automatic string byp_tag();
        if (nb) return "R7";
        if (tp) return sd ? "R6" : "R5";
        return "R4";
    endfunction

    task automatic check_state(string rtag);
        logic eff;
        eff = e_en() | ~e_sre();
        chk({"R1 ", rtag}, {4'h0, rd_data[31:4]}, 32'h0);
        chk({"R2 ", rtag}, {31'h0, rd_data[3]}, {31'h0, e_en()});
        chk({"R2 trap ", rtag}, {31'h0, trap_lower}, {31'h0, ~eff});
        chk({"R3 eff ", rtag}, {31'h0, eff_enable}, {31'h0, eff});
        chk({byp_tag(), " ", rtag}, {30'h0, rd_data[2:1]}, {30'h0, e_dib(), e_dfb()});
        chk({"R4 outs ", rtag}, {30'h0, irq_bypass_off, fiq_bypass_off},
            {30'h0, e_dib(), e_dfb()});
        chk({so ? "R8 " : "R11 ", rtag}, {31'h0, rd_data[0]}, {31'h0, e_sre()});
        chk({"R9 ", rtag}, {31'h0, sysreg_undef}, {31'h0, ~e_sre()});
        chk({"R10 ", rtag}, {31'h0, sre_clear_err}, {31'h0, m_err});
    endtask

    task automatic do_write(logic [3:0] v, logic [27:0] junk, logic [3:0] strb);
        logic fire;
        @(negedge clk);
        wr_en = 1'b1; wr_strb = strb; wr_data = {junk, v};
        fire = strb[0];
        #1;
        chk("R6 fwd", {31'h0, up_wr_en}, {31'h0, fire && tp && sd && !nb});
        if (fire && tp && sd && !nb)
            chk("R6 fwd data", {30'h0, up_wr_dib, up_wr_dfb}, {30'h0, v[2], v[1]});
        @(posedge clk);
        if (fire) begin
            if (!so) begin
                if (e_sre() && !v[0]) m_err = 1'b1;
                m_sre = v[0];
            end
            if (!(so && lk)) m_en = v[3];
            if (!nb && !tp) begin m_dib = v[2]; m_dfb = v[1]; end
        end
        @(negedge clk);
        wr_en = 1'b0; wr_strb = 4'h0;
        #1;
        check_state(fire ? "write" : "R11 strobe-off");
    endtask

    initial begin
        fork
            begin
                for (int c = 0; c < 32; c++) begin
                    @(negedge clk);
                    rst = 1'b1;
                    {nb, so, lk, tp, sd} = c[4:0];
                    up_dib = 1'b0; up_dfb = 1'b0;
                    @(negedge clk);
                    @(negedge clk);
                    rst = 1'b0;
                    m_en = 0; m_dib = 0; m_dfb = 0; m_sre = 0; m_err = 0;
                    #1;
                    check_state("R11 reset");
                    for (int u = 0; u < 4; u++) begin
                        @(negedge clk);
                        {up_dib, up_dfb} = u[1:0];
                        for (int v = 0; v < 16; v++)
                            do_write(v[3:0], 28'h5A5A5A5 ^ {v[3:0], 24'h0}, 4'hF);
                        do_write(~{e_en(), e_dib(), e_dfb(), e_sre()}, 28'hFFFFFFF, 4'hE);
                    end
                end
            end
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule